// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while also acting as the clock master. It creates a shift clock from a programmable 16-bit divisor and drives that clock onto the link. It samples one data line at the trailing edge of every clock pulse and builds words that arrive least significant bit first. A word is 8 bits, or 9 bits when the wide mode is selected. In wide mode the extra bit is presented on its own output, apart from the data byte.

The host has two ways to start reception. A one-shot request arms the receiver for a single word, and the armed state clears itself once that word is complete. A level enable keeps the receiver taking words back to back for as long as it stays high. This level enable takes precedence over the one-shot request. When a word completes while the previous one is still unread, an overrun is flagged and the receiver halts. The host recovers from the error by dropping the level enable. The clock rests at its idle level whenever the receiver has no work or the port is disabled. A polarity input inverts both the idle level and the edges of the clock.

Top module: `smrx_top`

## Requirements
- R1: After reset, `rxDone`, `overrun` and `singleArmed` are 0, and `sclk` equals `clkInvert`.
- R2: Each level of the shift clock lasts `divisor`+1 clock cycles. `sclk` returns to its idle level (equal to `clkInvert`) on the cycle after `portEn` is low, and it stays there while no reception is enabled.
- R3: With `clkInvert`=1 the clock idles high and its pulses go low. With `clkInvert`=0 it idles low and its pulses go high. The data line is sampled at the trailing edge of each pulse, where the clock returns to its idle level.
- R4: The first bit received lands in `rxByte[0]`, and each following bit lands in the next higher position.
- R5: A one-cycle `singleReq` pulse sets `singleArmed`. The receiver then takes exactly one word, `singleArmed` clears as that word completes, and the clock stops.
- R6: While `contEn` is high, words are received back to back with no gap in the clock. Each word can be read in turn.
- R7: When `contEn` and the single request are both active, `singleArmed` clears after the first word and reception goes on with further words.
- R8: With `wideMode`=1 a word is 9 bits: the first 8 go to `rxByte` and the 9th goes to `rxBit9`. With `wideMode`=0, `rxBit9` is 0.
- R9: `rxDone` rises when a word completes, and a `readStrobe` pulse clears it. A read issued in the same cycle as a completion accepts the new word without raising an overrun.
- R10: If a word completes while `rxDone` is 1 and no read is issued in that cycle, `overrun` goes to 1, `rxByte` keeps the older word, and the clock stops.
- R11: A falling edge of `contEn` clears `overrun` on the next cycle, and so does `portEn` being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEn | input | 1 | Port enable |
| singleReq | input | 1 | One-cycle request to arm a single-word receive |
| contEn | input | 1 | Continuous receive enable |
| wideMode | input | 1 | 1 selects 9-bit words |
| clkInvert | input | 1 | Shift clock polarity (idle level) |
| divisor | input | 16 | Half-period divisor of the shift clock, minus one |
| readStrobe | input | 1 | Host read of the received byte |
| sdata | input | 1 | Serial data line |
| sclk | output | 1 | Generated shift clock |
| singleArmed | output | 1 | Single-word receive is pending |
| rxDone | output | 1 | Received word is available |
| rxByte | output | 8 | Received data byte |
| rxBit9 | output | 1 | Ninth received bit |
| overrun | output | 1 | Overrun error |

## Verification
The bench builds the block with its default 16-bit divisor and 8-bit data width. It uses divisor values from 0 to 4, so that words take only tens of cycles and many random single, wide and inverted-clock receptions fit into a short run. Divisor 0 gives a one-cycle half period, which is the tightest case for the sampling edge and for clock continuity between back-to-back words. The bench measures the half period and compares it with the divisor on every edge. It also exercises both enables together, an overrun left unread, recovery from it, and disabling the port in the middle of a word.

// File: rtl/smrx_pkg.sv
package smrx_pkg;
  localparam int DATA_W   = 8;
  localparam int WORD_MAX = DATA_W + 1;
  localparam int BIT_W    = $clog2(WORD_MAX + 1);

  typedef struct packed {
    logic sample;    // trailing clock edge: shift in one bit
    logic wordDone;  // last bit of a word is being sampled
    logic wide;      // current word is nine bits
    logic clrErr;    // clear the overrun flag
  } rxStrobe_t;
endpackage

// File: rtl/smrx_ctrl.sv
module smrx_ctrl
  import smrx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             singleReq,
  input  logic             contEn,
  input  logic             wideMode,
  input  logic             clkInvert,
  input  logic             overrun,
  input  logic [DIV_W-1:0] divisor,
  output logic             sclk,
  output logic             singleArmed,
  output rxStrobe_t        strb
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(DATA_W);

  state_t           state;
  logic [DIV_W-1:0] baudCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             phase;
  logic             wideQ;
  logic             contEnQ;
  logic             active;
  logic             tick;
  logic             lastBit;

  assign active  = portEn && (contEn || singleArmed) && !overrun;
  assign tick    = (state == S_RUN) && active && (baudCnt == '0);
  assign lastBit = bitCnt == (wideQ ? LAST_WIDE : LAST_NARROW);
  assign sclk    = phase ^ clkInvert;

  always_comb begin
    strb.sample   = tick && phase;
    strb.wordDone = tick && phase && lastBit;
    strb.wide     = wideQ;
    strb.clrErr   = !portEn || (contEnQ && !contEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      baudCnt     <= '0;
      bitCnt      <= '0;
      phase       <= 1'b0;
      wideQ       <= 1'b0;
      contEnQ     <= 1'b0;
      singleArmed <= 1'b0;
    end else begin
      contEnQ <= contEn;

      if (!portEn)            singleArmed <= 1'b0;
      else if (singleReq)     singleArmed <= 1'b1;
      else if (strb.wordDone) singleArmed <= 1'b0;

      case (state)
        S_IDLE: begin
          if (active) begin
            state   <= S_RUN;
            baudCnt <= divisor;
            bitCnt  <= '0;
            phase   <= 1'b0;
            wideQ   <= wideMode;
          end
        end
        S_RUN: begin
          if (!active) begin
            state <= S_IDLE;
            phase <= 1'b0;
          end else if (baudCnt != '0) begin
            baudCnt <= baudCnt - 1'b1;
          end else begin
            baudCnt <= divisor;
            phase   <= ~phase;
            if (phase) begin
              if (lastBit) begin
                bitCnt <= '0;
                wideQ  <= wideMode;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smrx_dp.sv
module smrx_dp
  import smrx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdata,
  input  logic              readStrobe,
  input  rxStrobe_t         strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              overrun
);
  logic [WORD_MAX-1:0] shiftReg;
  logic [WORD_MAX-1:0] shiftNext;

  assign shiftNext = {sdata, shiftReg[WORD_MAX-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxByte   <= '0;
      rxBit9   <= 1'b0;
      rxDone   <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (strb.sample) shiftReg <= shiftNext;

      if (strb.wordDone && (!rxDone || readStrobe)) begin
        rxByte <= strb.wide ? shiftNext[DATA_W-1:0] : shiftNext[WORD_MAX-1:1];
        rxBit9 <= strb.wide & shiftNext[WORD_MAX-1];
        rxDone <= 1'b1;
      end else if (readStrobe) begin
        rxDone <= 1'b0;
      end

      if (strb.clrErr)
        overrun <= 1'b0;
      else if (strb.wordDone && rxDone && !readStrobe)
        overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/smrx_top.sv
module smrx_top
  import smrx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              singleReq,
  input  logic              contEn,
  input  logic              wideMode,
  input  logic              clkInvert,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              readStrobe,
  input  logic              sdata,
  output logic              sclk,
  output logic              singleArmed,
  output logic              rxDone,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxBit9,
  output logic              overrun
);
  rxStrobe_t strb;

  smrx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .singleReq(singleReq),
    .contEn(contEn), .wideMode(wideMode), .clkInvert(clkInvert),
    .overrun(overrun), .divisor(divisor), .sclk(sclk),
    .singleArmed(singleArmed), .strb(strb)
  );

  smrx_dp u_dp (
    .clk(clk), .rstN(rstN), .sdata(sdata), .readStrobe(readStrobe),
    .strb(strb), .rxByte(rxByte), .rxBit9(rxBit9), .rxDone(rxDone),
    .overrun(overrun)
  );
endmodule

// File: rtl/smrx_chk.sv
module smrx_chk
  import smrx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              portEn,
  input logic              contEn,
  input logic              singleReq,
  input logic              readStrobe,
  input logic              clkInvert,
  input logic              sclk,
  input logic              singleArmed,
  input logic              rxDone,
  input logic [DATA_W-1:0] rxByte,
  input logic              overrun,
  input logic              wordDone
);
  assert_port_off_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (sclk == clkInvert));

  assert_single_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && !singleReq) |=> !singleArmed);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !wordDone) |=> !rxDone);

  assert_overrun_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> (rxDone && $stable(rxByte)));

  assert_overrun_halts_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> (sclk == clkInvert));

  assert_err_recover_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(contEn) |=> !overrun);
endmodule

bind smrx_top smrx_chk u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .contEn(contEn),
  .singleReq(singleReq), .readStrobe(readStrobe), .clkInvert(clkInvert),
  .sclk(sclk), .singleArmed(singleArmed), .rxDone(rxDone), .rxByte(rxByte),
  .overrun(overrun), .wordDone(strb.wordDone)
);

// File: tb/sim_smrx_top.sv
module sim_smrx_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 0, rstN = 0, portEn = 0, singleReq = 0, contEn = 0;
  logic wideMode = 0, clkInvert = 0, readStrobe = 0, sdata = 0;
  logic [15:0] divisor = 0;
  logic sclk, singleArmed, rxDone, rxBit9, overrun;
  logic [7:0] rxByte;

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  smrx_top u0 (
    .clk(clk), .rstN(rstN), .portEn(portEn), .singleReq(singleReq),
    .contEn(contEn), .wideMode(wideMode), .clkInvert(clkInvert),
    .divisor(divisor), .readStrobe(readStrobe), .sdata(sdata), .sclk(sclk),
    .singleArmed(singleArmed), .rxDone(rxDone), .rxByte(rxByte),
    .rxBit9(rxBit9), .overrun(overrun)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side slave: presents the next bit on each leading clock edge.
  logic [8:0] txq [0:7];
  int txHead = 0, bitIdx = 0;
  logic prevP = 0, ptrClr = 0, curP;
  always @(negedge clk) begin
    curP = sclk ^ clkInvert;
    if (ptrClr) begin
      txHead = 0;
      bitIdx = 0;
    end else if (curP && !prevP) begin
      sdata <= txq[txHead & 7][bitIdx];
      bitIdx++;
      if (bitIdx == (wideMode ? 9 : 8)) begin
        bitIdx = 0;
        txHead++;
      end
    end
    prevP <= curP;
  end

  function automatic logic [7:0] expByte(logic [8:0] w);
    return w[7:0];
  endfunction
  function automatic logic expBit9(logic [8:0] w, logic wide);
    return wide & w[8];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  task automatic clearPtr();
    ptrClr = 1;
    @(negedge clk);
    @(negedge clk);
    ptrClr = 0;
  endtask

  task automatic pulseRead();
    readStrobe = 1;
    @(negedge clk);
    readStrobe = 0;
  endtask

  task automatic waitDone(input int lim, output bit halfOk);
    logic prev;
    int lastEdge;
    prev = sclk;
    lastEdge = -1;
    halfOk = 1;
    for (int i = 0; i < lim && !rxDone; i++) begin
      @(negedge clk);
      if (sclk !== prev) begin
        if (lastEdge >= 0 && (cyc - lastEdge) != int'(divisor) + 1) halfOk = 0;
        lastEdge = cyc;
        prev = sclk;
      end
    end
  endtask

  task automatic doSingle(logic [8:0] w);
    bit ok;
    txq[0] = w;
    clearPtr();
    singleReq = 1;
    @(negedge clk);
    singleReq = 0;
    chk("R5 armed after request", singleArmed, 1);
    waitDone(4000, ok);
    chk("R9 done raised", rxDone, 1);
    chk("R4 byte lsb first", rxByte, expByte(w));
    chk("R8 ninth bit", rxBit9, expBit9(w, wideMode));
    chk("R2 half period", ok, 1);
    chk("R5 armed cleared", singleArmed, 0);
    repeat (3 * (int'(divisor) + 2)) @(negedge clk);
    chk("R3 idle level after word", sclk, clkInvert);
    chk("R5 no further word", rxDone, 1);
    pulseRead();
    chk("R9 read clears done", rxDone, 0);
  endtask

  initial begin
    bit ok;
    logic [8:0] w;
    logic [8:0] cw [0:3];
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) txq[k] = '0;
    repeat (3) @(negedge clk);
    chk("R1 done at reset", rxDone, 0);
    chk("R1 overrun at reset", overrun, 0);
    chk("R1 armed at reset", singleArmed, 0);
    chk("R1 clock idle at reset", sclk, 0);
    rstN = 1;
    portEn = 1;
    @(negedge clk);
    chk("R2 idle without enables", sclk, clkInvert);

    // Directed corners
    divisor = 0; wideMode = 0; clkInvert = 0; doSingle(9'h0A5);
    divisor = 0; wideMode = 1; clkInvert = 1; doSingle(9'h1FF);
    divisor = 2; wideMode = 1; clkInvert = 0; doSingle(9'h100);
    divisor = 4; wideMode = 0; clkInvert = 1; doSingle(9'h181);

    // Constrained random singles
    for (int n = 0; n < 20; n++) begin
      divisor = 16'($urandom % 5);
      wideMode = 1'($urandom % 2);
      clkInvert = 1'($urandom % 2);
      w = 9'($urandom);
      @(negedge clk);
      chk("R3 idle follows polarity", sclk, clkInvert);
      doSingle(w);
    end

    // R6 continuous back to back
    divisor = 0; wideMode = 0; clkInvert = 0;
    for (int k = 0; k < 4; k++) begin
      cw[k] = 9'($urandom);
      txq[k] = cw[k];
    end
    txq[4] = '0;
    clearPtr();
    contEn = 1;
    for (int k = 0; k < 4; k++) begin
      waitDone(2000, ok);
      chk("R6 continuous word", rxByte, expByte(cw[k]));
      chk("R6 continuous clock", ok, 1);
      pulseRead();
    end
    contEn = 0;
    repeat (4) @(negedge clk);
    chk("R6 stops when cleared", sclk, clkInvert);
    chk("R6 no pending word", rxDone, 0);

    // R7 both enables
    divisor = 1; clkInvert = 1;
    txq[0] = 9'h03C; txq[1] = 9'h0C3;
    clearPtr();
    contEn = 1; singleReq = 1;
    @(negedge clk);
    singleReq = 0;
    waitDone(2000, ok);
    chk("R7 first word", rxByte, 8'h3C);
    chk("R7 single flag cleared", singleArmed, 0);
    pulseRead();
    waitDone(2000, ok);
    chk("R7 continuous wins", rxByte, 8'hC3);
    pulseRead();
    contEn = 0;
    repeat (6) @(negedge clk);
    if (rxDone) pulseRead();

    // R10 overrun, R11 recovery
    divisor = 0; clkInvert = 0; wideMode = 0;
    txq[0] = 9'h05A; txq[1] = 9'h0E7;
    clearPtr();
    contEn = 1;
    waitDone(2000, ok);
    chk("R10 first word", rxByte, 8'h5A);
    for (int i = 0; i < 200 && !overrun; i++) @(negedge clk);
    chk("R10 overrun raised", overrun, 1);
    chk("R10 older word kept", rxByte, 8'h5A);
    repeat (20) @(negedge clk);
    chk("R10 clock halted", sclk, clkInvert);
    chk("R10 done still set", rxDone, 1);
    contEn = 0;
    @(negedge clk);
    chk("R11 overrun cleared", overrun, 0);
    pulseRead();
    chk("R9 read after recovery", rxDone, 0);

    // R2 port disable mid-word
    divisor = 3;
    clearPtr();
    contEn = 1;
    repeat (13) @(negedge clk);
    portEn = 0;
    @(negedge clk);
    chk("R2 port off idle", sclk, clkInvert);
    contEn = 0;
    repeat (3) @(negedge clk);
    portEn = 1;
    chk("R2 no word after abort", rxDone, 0);

    summary();
  end

  initial begin
    wait (cyc >= 150000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    summary();
  end
endmodule